// File: doc/BRIEF.md
# Max-log-MAP Soft-In Soft-Out Decoder Core

This core decodes one block of a rate-1/2 recursive systematic convolutional constituent code. It uses the max-log approximation: every log-sum of exponentials is replaced by a plain maximum. The trellis has four states. The feedback taps are 1+D+D² and the feedforward taps are 1+D². The trellis starts and ends in state 0. A single instance serves both constituent decoders of an iterative scheme, and the `dec_sel` input chosen at `start` picks which decoder it acts as. Interleaving and iteration control stay outside the core.

All bulk storage lives behind one synchronous single-port memory port, which has a read latency of one cycle. The core reads one input word per symbol. That word holds the systematic soft value, the parity soft value and the a priori value. The backward pass walks the block from the last symbol down to the first and spills each normalized beta vector to memory. The forward pass then runs the alpha recursion, reads back the matching beta vector, and forms the LLR. It writes the extrinsic value to memory and offers the saturated LLR on a valid/ready output stream.

On the output stream, `out_llr` is held steady while `out_valid` is high and `out_ready` is low. The core never drops or reorders a word. Each forward symbol has a 14-cycle budget. A word that is still unaccepted in the last cycle of that budget freezes the forward pass until the word is taken. The backward pass never stalls.

Top module: `mlm_siso_core`

## Requirements
- R1: Trellis state s={r1,r2}. For input bit u, the feedback bit is a=u^r1^r2, the parity bit is p=a^r2, and the next state is {a,r1}. The branch metric is u·(sys+apri)+p·par. Both recursions start from metric 0 in state 0 and a metric of -4096 in every other state. `out_llr` for symbol k equals the saturated value of (best u=1 path − best u=0 path).
- R2: The extrinsic value is the saturated value of (unsaturated LLR − sys − apri). It is written to bits [7:0] of address (3+sel)·BLK+k.
- R3: The backward pass computes beta_k and subtracts its state-0 entry. It writes states 1, 2 and 3 to address 2·BLK+k in fields [MW-1:0], [2MW-1:MW] and [3MW-1:2MW].
- R4: The backward pass handles one symbol every 12 cycles, in descending order from k=BLK-1 to k=0.
- R5: The forward pass takes 14 cycles per symbol when the output stream does not stall. With `out_ready` held high, `done` rises exactly 26·BLK cycles after the clock edge that accepts `start`.
- R6: The input word of symbol k is read from sel·BLK+k, with sys in [7:0], par in [15:8] and apri in [23:16]. The core writes only to the beta region and to the extrinsic region of the selected decoder. It never writes to the input regions.
- R7: Both `out_llr` and the extrinsic value saturate to [-128, 127].
- R8: One LLR word is issued per symbol, in order from k=0 upward. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_llr` does not change.
- R9: `start` has no effect while a block is being decoded. `done` is a one-cycle pulse.
- R10: After reset, `out_valid`, `done` and `mem_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a block (accepted only while idle) |
| dec_sel | input | 1 | Constituent decoder select, captured at start |
| done | output | 1 | One-cycle pulse after the last symbol |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | 3·MW | Memory write data |
| mem_rdata | input | 3·MW | Memory read data, valid one cycle after the read |
| out_valid | output | 1 | LLR word available |
| out_ready | input | 1 | Sink accepts the LLR word |
| out_llr | output | 8 | Saturated LLR of the current symbol |

## Verification
The properties assume that `mem_rdata` returns the addressed word one cycle after a read and that nothing else writes to memory during a block. The stimulus meets this with a bench-side memory model, and it loads that memory only while the core is idle. The properties do not depend on `out_ready`, which may change on any cycle. The stimulus holds it high in some runs, toggles it pseudo-randomly in others, and raises `start` once in the middle of a block. Soft inputs stay within 8 bits, and the 16-bit metrics have ample headroom over the normalized spread for those inputs.

// File: rtl/mlm_pkg.sv
`timescale 1ns/1ps
package mlm_pkg;
  localparam int SW = 8;  // soft value width

  typedef enum logic [1:0] {PH_IDLE, PH_BWD, PH_FWD} phase_t;

  // state s = {r1, r2}; feedback taps 1+D+D^2, feedforward taps 1+D^2
  function automatic logic [1:0] trel_next(input logic [1:0] s, input logic u);
    return {u ^ s[1] ^ s[0], s[1]};
  endfunction

  function automatic logic trel_par(input logic [1:0] s, input logic u);
    return u ^ s[1];
  endfunction

  function automatic logic signed [SW-1:0] sat_soft(input int v);
    int hi;
    hi = (1 << (SW-1)) - 1;
    if (v > hi) return SW'(hi);
    if (v < -hi - 1) return SW'(-hi - 1);
    return SW'(v);
  endfunction
endpackage

// File: rtl/mlm_branch_stage.sv
`timescale 1ns/1ps
module mlm_branch_stage import mlm_pkg::*; #(
  parameter int MW = 16
) (
  input  logic                 clk,
  input  logic                 fwd,
  input  logic signed [SW-1:0] sys,
  input  logic signed [SW-1:0] par,
  input  logic signed [SW-1:0] apri,
  input  logic signed [MW-1:0] alpha [4],
  input  logic signed [MW-1:0] beta  [4],
  output logic signed [MW-1:0] cand_x [8],
  output logic signed [MW-1:0] cand_l [8]
);
  logic signed [MW-1:0] w_sys, w_par;

  assign w_sys = {{(MW-SW){sys[SW-1]}}, sys} + {{(MW-SW){apri[SW-1]}}, apri};
  assign w_par = {{(MW-SW){par[SW-1]}}, par};

  // one adder set per transition t = {s, u}
  for (genvar t = 0; t < 8; t++) begin : g_tr
    localparam logic [1:0] S  = 2'(t >> 1);
    localparam logic       U  = 1'(t & 1);
    localparam logic [1:0] NX = trel_next(S, U);
    localparam logic       P  = trel_par(S, U);
    logic signed [MW-1:0] gam;
    assign gam = (U ? w_sys : '0) + (P ? w_par : '0);
    always_ff @(posedge clk) begin
      cand_x[t] <= fwd ? alpha[S] + gam : gam + beta[NX];
      cand_l[t] <= alpha[S] + gam + beta[NX];
    end
  end
endmodule

// File: rtl/mlm_select_stage.sv
`timescale 1ns/1ps
module mlm_select_stage import mlm_pkg::*; #(
  parameter int MW = 16
) (
  input  logic signed [MW-1:0] cand_x [8],
  input  logic signed [MW-1:0] cand_l [8],
  output logic signed [MW-1:0] beta_new  [4],
  output logic signed [MW-1:0] alpha_new [4],
  output logic signed [MW-1:0] llr
);
  localparam logic signed [MW-1:0] FLOOR = {1'b1, {(MW-1){1'b0}}};

  logic signed [MW-1:0] b_raw [4];
  logic signed [MW-1:0] a_raw [4];
  logic signed [MW-1:0] best1, best0;

  always_comb begin
    for (int s = 0; s < 4; s++) begin
      b_raw[s] = (cand_x[2*s] > cand_x[2*s+1]) ? cand_x[2*s] : cand_x[2*s+1];
      a_raw[s] = FLOOR;
    end
    best1 = FLOOR;
    best0 = FLOOR;
    for (int t = 0; t < 8; t++) begin
      if (cand_x[t] > a_raw[trel_next(2'(t >> 1), t[0])])
        a_raw[trel_next(2'(t >> 1), t[0])] = cand_x[t];
      if (t[0]) begin
        if (cand_l[t] > best1) best1 = cand_l[t];
      end else begin
        if (cand_l[t] > best0) best0 = cand_l[t];
      end
    end
    for (int s = 0; s < 4; s++) begin
      beta_new[s]  = b_raw[s] - b_raw[0];
      alpha_new[s] = a_raw[s] - a_raw[0];
    end
    llr = best1 - best0;
  end
endmodule

// File: rtl/mlm_siso_core.sv
`timescale 1ns/1ps
module mlm_siso_core import mlm_pkg::*; #(
  parameter int BLK = 16,
  parameter int MW  = 16,
  localparam int DW = 3 * MW,
  localparam int AW = $clog2(5 * BLK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dec_sel,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_llr
);
  localparam int KW = $clog2(BLK);
  localparam int BWD_CYC = 12;
  localparam int FWD_CYC = 14;
  localparam int NEG_I = -(2 ** (MW - 4));
  localparam logic [AW-1:0] BETA_BASE = AW'(2 * BLK);

  phase_t               phase;
  logic [3:0]           cnt;
  logic [KW-1:0]        k;
  logic                 sel_q;
  logic signed [SW-1:0] in_sys, in_par, in_apri, ext_r;
  logic signed [MW-1:0] llr_r, llr_c;
  logic signed [MW-1:0] beta_r [4];
  logic signed [MW-1:0] alpha_r [4];
  logic signed [MW-1:0] bnx_r [4];
  logic signed [MW-1:0] beta_in [4];
  logic signed [MW-1:0] cand_x [8];
  logic signed [MW-1:0] cand_l [8];
  logic signed [MW-1:0] beta_new [4];
  logic signed [MW-1:0] alpha_new [4];
  logic [AW-1:0]        in_addr, ext_addr;

  function automatic logic signed [MW-1:0] edge_metric(input int i);
    return (i == 0) ? '0 : MW'(NEG_I);
  endfunction

  always_comb for (int i = 0; i < 4; i++) beta_in[i] = (phase == PH_FWD) ? bnx_r[i] : beta_r[i];

  mlm_branch_stage #(.MW(MW)) u_branch (
    .clk(clk), .fwd(phase == PH_FWD), .sys(in_sys), .par(in_par), .apri(in_apri),
    .alpha(alpha_r), .beta(beta_in), .cand_x(cand_x), .cand_l(cand_l));

  mlm_select_stage #(.MW(MW)) u_select (
    .cand_x(cand_x), .cand_l(cand_l), .beta_new(beta_new), .alpha_new(alpha_new), .llr(llr_c));

  assign in_addr  = (sel_q ? AW'(BLK) : '0) + AW'(k);
  assign ext_addr = (sel_q ? AW'(4 * BLK) : AW'(3 * BLK)) + AW'(k);

  always_comb begin
    mem_en = 1'b0;
    mem_we = 1'b0;
    mem_addr = '0;
    mem_wdata = '0;
    if (phase == PH_BWD) begin
      if (cnt == 4'd0) begin
        mem_en = 1'b1; mem_addr = in_addr;
      end else if (cnt == 4'd4) begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = BETA_BASE + AW'(k);
        mem_wdata = {beta_r[3], beta_r[2], beta_r[1]};
      end
    end else if (phase == PH_FWD) begin
      if (cnt == 4'd0) begin
        mem_en = 1'b1; mem_addr = in_addr;
      end else if (cnt == 4'd2 && k != KW'(BLK - 1)) begin
        mem_en = 1'b1; mem_addr = BETA_BASE + AW'(k) + AW'(1);
      end else if (cnt == 4'd7) begin
        mem_en = 1'b1; mem_we = 1'b1; mem_addr = ext_addr;
        mem_wdata = {{(DW-SW){1'b0}}, ext_r};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE; cnt <= '0; k <= '0; sel_q <= 1'b0;
      done <= 1'b0; out_valid <= 1'b0; out_llr <= '0;
      in_sys <= '0; in_par <= '0; in_apri <= '0; llr_r <= '0; ext_r <= '0;
      for (int i = 0; i < 4; i++) begin
        beta_r[i] <= edge_metric(i); alpha_r[i] <= edge_metric(i); bnx_r[i] <= edge_metric(i);
      end
    end else begin
      done <= 1'b0;
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (phase != PH_IDLE && cnt == 4'd1) begin
        in_sys  <= mem_rdata[SW-1:0];
        in_par  <= mem_rdata[2*SW-1:SW];
        in_apri <= mem_rdata[3*SW-1:2*SW];
      end
      case (phase)
        PH_IDLE: if (start) begin
          phase <= PH_BWD; sel_q <= dec_sel; cnt <= '0; k <= KW'(BLK - 1);
          for (int i = 0; i < 4; i++) begin
            beta_r[i] <= edge_metric(i); alpha_r[i] <= edge_metric(i);
          end
        end
        PH_BWD: begin
          if (cnt == 4'd3) beta_r <= beta_new;
          if (cnt == 4'(BWD_CYC - 1)) begin
            cnt <= '0;
            if (k == '0) phase <= PH_FWD;
            else k <= k - 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        PH_FWD: begin
          if (cnt == 4'd3) begin
            for (int i = 0; i < 4; i++)
              bnx_r[i] <= (k == KW'(BLK - 1) || i == 0) ? edge_metric(i) : mem_rdata[(i-1)*MW +: MW];
          end
          if (cnt == 4'd5) begin
            llr_r <= llr_c; alpha_r <= alpha_new;
          end
          if (cnt == 4'd6) begin
            ext_r <= sat_soft(int'(llr_r) - int'(in_sys) - int'(in_apri));
            out_llr <= sat_soft(int'(llr_r));
            out_valid <= 1'b1;
          end
          if (cnt == 4'(FWD_CYC - 1)) begin
            if (!out_valid || out_ready) begin
              cnt <= '0;
              if (k == KW'(BLK - 1)) begin
                phase <= PH_IDLE; done <= 1'b1;
              end else k <= k + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mlm_siso_chk.sv
`timescale 1ns/1ps
module mlm_siso_chk #(
  parameter int BLK = 16,
  localparam int AW = $clog2(5 * BLK)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          done,
  input logic          mem_en,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          out_valid,
  input logic          out_ready,
  input logic [7:0]    out_llr
);
  logic       wr_beta, wr_ext;
  logic [4:0] gap_b, gap_e;
  logic       seen_b, seen_e;

  assign wr_beta = mem_en && mem_we && mem_addr >= AW'(2 * BLK) && mem_addr < AW'(3 * BLK);
  assign wr_ext  = mem_en && mem_we && mem_addr >= AW'(3 * BLK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_b <= '0; gap_e <= '0; seen_b <= 1'b0; seen_e <= 1'b0;
    end else begin
      if (wr_beta) begin gap_b <= '0; seen_b <= 1'b1; end
      else if (gap_b != 5'd31) gap_b <= gap_b + 1'b1;
      if (wr_ext) begin gap_e <= '0; seen_e <= 1'b1; end
      else if (gap_e != 5'd31) gap_e <= gap_e + 1'b1;
      if (done) begin seen_b <= 1'b0; seen_e <= 1'b0; end
    end
  end

  p_beta_pace_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beta && seen_b |-> gap_b == 5'd11);
  p_ext_pace_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ext && seen_e |-> gap_e >= 5'd13);
  p_input_untouched_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we |-> mem_addr >= AW'(2 * BLK));
  p_hold_llr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_llr));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mlm_siso_core mlm_siso_chk #(.BLK(BLK)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(done), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .out_valid(out_valid), .out_ready(out_ready), .out_llr(out_llr));

// File: tb/mlm_siso_core_test.sv
`timescale 1ns/1ps
module mlm_siso_core_test;
  localparam int N = 16;
  localparam int MW = 16;
  localparam int DW = 3 * MW;
  localparam int AW = $clog2(5 * N);
  localparam int NEG = -4096;

  logic clk = 0, rst_n = 0, start = 0, dec_sel = 0, out_ready = 1;
  logic done, mem_en, mem_we, out_valid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [7:0] out_llr;

  mlm_siso_core #(.BLK(N), .MW(MW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .dec_sel(dec_sel), .done(done),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready), .out_llr(out_llr));

  initial forever #10 clk = ~clk;  // 50 MHz

  logic [DW-1:0] mem [5*N];
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      else mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, fails = 0;
  int exp_q[$];
  int ys[N], yp[N], la[N], ext_exp[N];
  int bet[N+1][4];
  bit bp_on = 0;
  logic [DW-1:0] SENT = 48'h5A5A_5A5A_5A5A;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int clamp8(input int v);
    return v > 127 ? 127 : (v < -128 ? -128 : v);
  endfunction
  function automatic int nxs(input int s, input int u);
    return ((u ^ (s >> 1) ^ (s & 1)) << 1) | (s >> 1);
  endfunction
  function automatic int pbit(input int s, input int u);
    return u ^ (s >> 1);
  endfunction
  function automatic int gm(input int k, input int s, input int u);
    return u * (ys[k] + la[k]) + pbit(s, u) * yp[k];
  endfunction

  // behavioural max-log reference; pushes expected LLRs into the scoreboard
  task automatic reference();
    int al[4], na[4], m, c, m1, m0;
    for (int s = 0; s < 4; s++) bet[N][s] = (s == 0) ? 0 : NEG;
    for (int k = N - 1; k >= 0; k--) begin
      for (int s = 0; s < 4; s++) begin
        m = gm(k, s, 0) + bet[k+1][nxs(s, 0)];
        c = gm(k, s, 1) + bet[k+1][nxs(s, 1)];
        bet[k][s] = c > m ? c : m;
      end
      m = bet[k][0];
      for (int s = 0; s < 4; s++) bet[k][s] -= m;
    end
    for (int s = 0; s < 4; s++) al[s] = (s == 0) ? 0 : NEG;
    for (int k = 0; k < N; k++) begin
      m1 = -1000000; m0 = -1000000;
      for (int s = 0; s < 4; s++) na[s] = -1000000;
      for (int s = 0; s < 4; s++) for (int u = 0; u < 2; u++) begin
        c = al[s] + gm(k, s, u);
        if (c > na[nxs(s, u)]) na[nxs(s, u)] = c;
        c += bet[k+1][nxs(s, u)];
        if (u == 1 && c > m1) m1 = c;
        if (u == 0 && c > m0) m0 = c;
      end
      exp_q.push_back(clamp8(m1 - m0));
      ext_exp[k] = clamp8(m1 - m0 - ys[k] - la[k]);
      for (int s = 0; s < 4; s++) al[s] = na[s] - na[0];
    end
  endtask

  task automatic build(input bit sel, input int amp, input int nz, input int aamp);
    int st, u, p, a;
    st = 0;
    for (int k = 0; k < N; k++) begin
      u = (k < N - 2) ? int'($urandom % 2) : ((st >> 1) ^ (st & 1));
      p = pbit(st, u);
      a = u ^ (st >> 1) ^ (st & 1);
      st = (a << 1) | (st >> 1);
      ys[k] = clamp8((u ? amp : -amp) + int'($urandom % (2 * nz + 1)) - nz);
      yp[k] = clamp8((p ? amp : -amp) + int'($urandom % (2 * nz + 1)) - nz);
      la[k] = (aamp == 0) ? 0 : clamp8(int'($urandom % (2 * aamp + 1)) - aamp);
      mem[(sel ? N : 0) + k] = {24'b0, 8'(la[k]), 8'(yp[k]), 8'(ys[k])};
      mem[3*N + k] = SENT;
      mem[4*N + k] = SENT;
    end
    reference();
  endtask

  // monitor: pops the scoreboard on every accepted word, checks stalls
  bit stall_prev = 0;
  logic [7:0] llr_prev;
  initial forever begin
    @(negedge clk);
    if (stall_prev) chk(out_valid && out_llr == llr_prev, "R8 stall hold", int'(out_llr), int'(llr_prev));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R8 extra word", int'($signed(out_llr)), 0);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(int'($signed(out_llr)) == e, "R1/R7 llr", int'($signed(out_llr)), e);
      end
    end
    stall_prev = out_valid && !out_ready;
    llr_prev = out_llr;
  end

  initial forever begin
    @(posedge clk);
    #2 out_ready = bp_on ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic run_block(input bit sel, input int amp, input int nz, input int aamp,
                           input bit bp, input bit poke);
    int cyc;
    build(sel, amp, nz, aamp);
    bp_on = bp;
    @(negedge clk);
    dec_sel = sel; start = 1;
    @(negedge clk);
    start = 0;
    cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (poke && cyc == 50) begin start = 1; dec_sel = !sel; end  // R9: must be ignored
      if (poke && cyc == 51) begin start = 0; dec_sel = sel; end
      if (done) break;
    end
    chk(done, "R5 done seen", int'(done), 1);
    if (!bp) chk(cyc == 26 * N, "R4/R5 latency", cyc, 26 * N);
    @(negedge clk);
    chk(!done, "R9 done pulse", int'(done), 0);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R8 word count", exp_q.size(), 0);
    for (int k = 0; k < N; k++) begin
      chk(int'($signed(mem[(3 + sel) * N + k][7:0])) == ext_exp[k], "R2/R7 extrinsic",
          int'($signed(mem[(3 + sel) * N + k][7:0])), ext_exp[k]);
      chk(mem[(4 - sel) * N + k] == SENT, "R6/R9 other region untouched",
          int'(mem[(4 - sel) * N + k][15:0]), int'(SENT[15:0]));
      for (int j = 1; j < 4; j++)
        chk(int'($signed(mem[2*N + k][(j-1)*MW +: MW])) == bet[k][j], "R3 beta",
            int'($signed(mem[2*N + k][(j-1)*MW +: MW])), bet[k][j]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R10 out_valid", int'(out_valid), 0);
    chk(!done, "R10 done", int'(done), 0);
    chk(!mem_en, "R10 mem_en", int'(mem_en), 0);
    run_block(0, 30, 40, 0, 0, 1);     // R6: decoder 0, stray start mid-block
    run_block(1, 20, 30, 30, 1, 0);    // decoder 1 with back-pressure
    run_block(0, 127, 0, 127, 1, 0);   // R7: strong inputs drive saturation
    run_block(1, 10, 60, 0, 0, 0);     // noisy block, no stall
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule